// File: doc/BRIEF.md
# Source Status Change Interrupt Register

This block is the register file and interrupt logic that sits behind the serial-bus slave of a signal-routing switch. Seven 8-bit control registers can be written and read back through a simple synchronous register port. The port has an address, write data, a write strobe, a read strobe and registered read data. Two external sources each present a 2-bit status code. The block brings each code into its own clock domain through a flop synchronizer and publishes both codes in a read-only status byte.

A change of either code raises an interrupt flag, but only while the host has armed it. The flag shows in the status byte and drives an active-low interrupt pin. Reading the status byte clears the flag. Arming is one-shot: the enable bit in control register 0x04 clears itself when the flag is raised. The host must write a 1 to it again before another change can interrupt.

Top module: `status_irq`

## Requirements
- R1: After reset, control registers 0x00 to 0x06 all read 0x00, the status flag reads 0 and `irqN` is high.
- R2: A write to an address from 0x00 to 0x06 stores the whole byte, and a later read of that address returns it.
- R3: Reading address 0x07 returns the status byte. Bits 1:0 hold source A's synchronized code and bits 3:2 hold source B's. Bit 4 is the flag, and bits 7:5 are 0. The codes are 01 for an input level under 2 V, 10 for a 16:9 request and 11 for a 4:3 request.
- R4: While bit 7 of register 0x04 is 1, a change of either code sets the flag and pulls `irqN` low. This happens on the third rising edge after the input changes, and not earlier.
- R5: A status read returns the flag as it was before the read, then clears it and releases `irqN`.
- R6: Setting the flag clears bit 7 of register 0x04 and leaves its other bits unchanged. Further changes then leave the flag at 0 until the host writes a 1 to that bit again.
- R7: While bit 7 of register 0x04 is 0, a code change leaves the flag at 0 and `irqN` high.
- R8: A change detected on the same cycle as a status read while armed leaves the flag set after the read. The read itself returns the old flag value.
- R9: Writes to addresses 0x07 and above change no register. Reads from 0x08 and above return 0x00.
- R10: `regRdata` updates on the rising edge that samples `regRd` high and holds its value while `regRd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address |
| regWdata | input | 8 | Write data |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read strobe, one cycle per read |
| regRdata | output | 8 | Registered read data |
| srcACode | input | 2 | Raw status code of source A |
| srcBCode | input | 2 | Raw status code of source B |
| irqN | output | 1 | Interrupt, low while the flag is set |

## Verification
The assertions assume that `regWr` and `regRd` are never high together. They also assume that the source codes need only the synchronizer's settling time, with no protocol beyond it. The stimulus keeps to this by issuing one register operation per task call, with the strobes dropped in between. Source inputs are changed only at falling clock edges and held for several cycles. The one deliberate overlap, a status read aligned to the detection cycle, is timed by counting the two synchronizer stages.

// File: rtl/status_irq_pkg.sv
package status_irq_pkg;
  localparam int CTRL_COUNT = 7;
  localparam int CTRL_IDX_W = $clog2(CTRL_COUNT);
  localparam int SRC_COUNT  = 2;
  localparam int CODE_W     = 2;
  localparam int FLAG_POS   = SRC_COUNT * CODE_W;

  // Decoded strobes handed from control to datapath
  typedef struct packed {
    logic                  ctrlWr;
    logic [CTRL_IDX_W-1:0] ctrlIdx;
    logic                  rdCtrl;
    logic                  rdStatus;
    logic                  rdAny;
  } regStrobes_t;
endpackage

// File: rtl/status_irq_sync.sv
module status_irq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/status_irq_ctrl.sv
module status_irq_ctrl
  import status_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int STATUS_ADDR = 7
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output regStrobes_t       strobes
);
  logic inCtrl;
  logic isStatus;

  always_comb begin
    inCtrl   = regAddr < ADDR_W'(CTRL_COUNT);
    isStatus = regAddr == ADDR_W'(STATUS_ADDR);
    strobes.ctrlWr   = regWr && inCtrl;
    strobes.ctrlIdx  = regAddr[CTRL_IDX_W-1:0];
    strobes.rdCtrl   = regRd && inCtrl;
    strobes.rdStatus = regRd && isStatus;
    strobes.rdAny    = regRd;
  end
endmodule

// File: rtl/status_irq_dp.sv
module status_irq_dp
  import status_irq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IRQ_REG     = 4,
  parameter int IRQ_BIT     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  regStrobes_t                        strobes,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [SRC_COUNT-1:0][CODE_W-1:0]   srcCodes,
  output logic [DATA_W-1:0]                  rdata,
  output logic                               irqFlag,
  output logic                               irqArmed,
  output logic                               changeSeen
);
  logic [SRC_COUNT-1:0][CODE_W-1:0] syncCodes;
  logic [SRC_COUNT-1:0][CODE_W-1:0] prevCodes;
  logic [DATA_W-1:0] ctrlRegs [CTRL_COUNT];
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] rdNext;
  logic              setEvent;

  for (genvar s = 0; s < SRC_COUNT; s++) begin : g_src
    status_irq_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (srcCodes[s]),
      .dout (syncCodes[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevCodes <= '0;
    else        prevCodes <= syncCodes;
  end

  assign changeSeen = syncCodes != prevCodes;
  assign irqArmed   = ctrlRegs[IRQ_REG][IRQ_BIT];
  assign setEvent   = changeSeen && irqArmed;

  // Self-disarm on set; a host write in the same cycle takes precedence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CTRL_COUNT; i++) ctrlRegs[i] <= '0;
    end else begin
      if (setEvent) ctrlRegs[IRQ_REG][IRQ_BIT] <= 1'b0;
      if (strobes.ctrlWr) ctrlRegs[strobes.ctrlIdx] <= wdata;
    end
  end

  // Set beats clear so a change during a status read is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irqFlag <= 1'b0;
    else if (setEvent)         irqFlag <= 1'b1;
    else if (strobes.rdStatus) irqFlag <= 1'b0;
  end

  always_comb begin
    statusWord = '0;
    statusWord[FLAG_POS-1:0] = syncCodes;
    statusWord[FLAG_POS]     = irqFlag;
  end

  always_comb begin
    if (strobes.rdCtrl)        rdNext = ctrlRegs[strobes.ctrlIdx];
    else if (strobes.rdStatus) rdNext = statusWord;
    else                       rdNext = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rdata <= '0;
    else if (strobes.rdAny) rdata <= rdNext;
  end
endmodule

// File: rtl/status_irq.sv
module status_irq
  import status_irq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 7,
  parameter int IRQ_REG     = 4,
  parameter int IRQ_BIT     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  output logic [DATA_W-1:0] regRdata,
  input  logic [CODE_W-1:0] srcACode,
  input  logic [CODE_W-1:0] srcBCode,
  output logic              irqN
);
  regStrobes_t strobes;
  logic        irqFlag;
  logic        irqArmed;
  logic        changeSeen;

  status_irq_ctrl #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_ctrl (
    .regAddr(regAddr),
    .regWr  (regWr),
    .regRd  (regRd),
    .strobes(strobes)
  );

  status_irq_dp #(
    .DATA_W(DATA_W), .IRQ_REG(IRQ_REG), .IRQ_BIT(IRQ_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wdata     (regWdata),
    .srcCodes  ({srcBCode, srcACode}),
    .rdata     (regRdata),
    .irqFlag   (irqFlag),
    .irqArmed  (irqArmed),
    .changeSeen(changeSeen)
  );

  assign irqN = ~irqFlag;
endmodule

// File: rtl/status_irq_chk.sv
module status_irq_chk #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 7,
  parameter int IRQ_REG     = 4,
  parameter int IRQ_BIT     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regWr,
  input logic              regRd,
  input logic [DATA_W-1:0] regRdata,
  input logic              irqN,
  input logic              irqArmed,
  input logic              changeSeen
);
  logic statusRd;
  logic armWrite;
  assign statusRd = regRd && (regAddr == ADDR_W'(STATUS_ADDR));
  assign armWrite = regWr && (regAddr == ADDR_W'(IRQ_REG)) && regWdata[IRQ_BIT];

  a_r7_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqArmed && irqN) |=> irqN);

  a_r6_disarm_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqN) |-> (!irqArmed || $past(armWrite)));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRd && !(changeSeen && irqArmed)) |=> irqN);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRd && changeSeen && irqArmed) |=> !irqN);

  a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !regRd |=> $stable(regRdata));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    statusRd |=> (regRdata[DATA_W-1:5] == '0));

  a_r9_high_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (regRd && regAddr > ADDR_W'(STATUS_ADDR)) |=> (regRdata == '0));
endmodule

bind status_irq status_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR),
  .IRQ_REG(IRQ_REG), .IRQ_BIT(IRQ_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .regWr     (regWr),
  .regRd     (regRd),
  .regRdata  (regRdata),
  .irqN      (irqN),
  .irqArmed  (irqArmed),
  .changeSeen(changeSeen)
);

// File: tb/status_irq_tb.sv
module status_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regRdata;
  logic [1:0] srcACode = '0;
  logic [1:0] srcBCode = '0;
  logic       irqN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic rdLatched = 1'b0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2 clk = ~clk;

  status_irq u_dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .regRdata(regRdata),
    .srcACode(srcACode), .srcBCode(srcBCode), .irqN(irqN)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: a read captured at a posedge is compared at the next negedge
  always @(posedge clk) rdLatched <= regRd;
  always @(negedge clk) begin
    if (rdLatched && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(regRdata === e, t, regRdata, e);
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic setSrc(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    srcACode = a; srcBCode = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(irqN === 1'b1, "R1 irqN after reset", {7'b0, irqN}, 8'h01);
    for (int i = 0; i < 7; i++) rdReg(8'(i), 8'h00, "R1 control reset value");
    rdReg(8'h07, 8'h00, "R1 status after reset");

    for (int i = 0; i < 7; i++) wrReg(8'(i), 8'(8'h30 + i));
    for (int i = 0; i < 7; i++) rdReg(8'(i), 8'(8'h30 + i), "R2 readback");

    wrReg(8'h07, 8'hFF);
    wrReg(8'h09, 8'hFF);
    rdReg(8'h07, 8'h00, "R9 status unaffected by write");
    rdReg(8'h09, 8'h00, "R9 high address reads zero");
    rdReg(8'h06, 8'h36, "R9 registers unchanged");

    // R7: change while disarmed
    setSrc(2'b01, 2'b00);
    repeat (4) @(negedge clk);
    check(irqN === 1'b1, "R7 no irq when disarmed", {7'b0, irqN}, 8'h01);
    rdReg(8'h07, 8'h01, "R3 source A code below 2 V");

    // R4: arm then change
    wrReg(8'h04, 8'hB4);
    setSrc(2'b10, 2'b01);
    repeat (2) @(negedge clk);
    check(irqN === 1'b1, "R4 not before third edge", {7'b0, irqN}, 8'h01);
    @(negedge clk);
    check(irqN === 1'b0, "R4 irq on third edge", {7'b0, irqN}, 8'h00);
    rdReg(8'h04, 8'h34, "R6 enable self-cleared");
    rdReg(8'h07, 8'h16, "R5 read returns flag and codes");
    check(irqN === 1'b1, "R5 irq released by read", {7'b0, irqN}, 8'h01);
    rdReg(8'h07, 8'h06, "R5 flag cleared");

    // R6: no re-arm, change ignored
    setSrc(2'b10, 2'b11);
    repeat (4) @(negedge clk);
    check(irqN === 1'b1, "R6 one-shot until rearm", {7'b0, irqN}, 8'h01);
    rdReg(8'h07, 8'h0E, "R6 status without flag, R3 4:3 code");

    wrReg(8'h04, 8'h80);
    setSrc(2'b11, 2'b11);
    repeat (4) @(negedge clk);
    check(irqN === 1'b0, "R6 rearmed irq", {7'b0, irqN}, 8'h00);
    rdReg(8'h07, 8'h1F, "R3 both codes 4:3 with flag");

    // R8: read in the detection cycle
    wrReg(8'h04, 8'h80);
    setSrc(2'b01, 2'b11);
    @(negedge clk);
    rdReg(8'h07, 8'h0D, "R8 read returns old flag");
    check(irqN === 1'b0, "R8 flag kept after colliding read", {7'b0, irqN}, 8'h00);
    rdReg(8'h07, 8'h1D, "R8 flag visible");

    // R10: rdata holds with no read
    repeat (3) @(negedge clk);
    check(regRdata === 8'h1D, "R10 rdata holds", regRdata, 8'h1D);
    rdReg(8'h20, 8'h00, "R10 rdata updates on read");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule